// File: doc/BRIEF.md
# Per-Load Stride Prefetch Engine

This block watches a stream of load accesses and learns, separately for each load instruction, the distance between the addresses it touches on successive executions. Each load is identified by its program counter. A small direct-mapped history table keeps, for every tracked load, a partial PC tag, the last data address it used, a learned stride and a two-bit confidence state. Every access that matches the entry moves the confidence state one step. Only when the stride has proved itself does the engine emit a prefetch for the address one stride ahead.

Requests leave through a single registered slot with a valid/ready handshake. If the consumer stalls, the slot holds its request. A newer qualifying load overwrites the held request, so the freshest prediction always wins and no queue builds up. The cache, the prefetch buffer and the memory system sit outside this block.

Top module: `spf_stride_prefetcher`

## Requirements
- R1: After reset `pf_valid` is 0 and every table entry is empty, so the first load of any PC is a tag miss.
- R2: On a tag miss the indexed entry is claimed for the new PC. Its last address becomes the load address, its stride becomes 0 and its state becomes init. No prefetch is issued.
- R3: A load is correct when its address equals the entry's last address plus the entry's stride, modulo 2^ADDR_W. A correct load in init moves the entry to steady and issues a prefetch.
- R4: An incorrect load in init moves the entry to transient and relearns the stride as the current address minus the last address. A correct load in transient then moves it to steady and issues a prefetch.
- R5: An incorrect load in transient moves the entry to no-prediction and relearns the stride. A correct load in no-prediction moves it to transient without issuing.
- R6: An incorrect load in steady drops the entry to init without issuing, and the stride is kept.
- R7: An incorrect load in no-prediction leaves the entry in no-prediction and relearns the stride.
- R8: A prefetch is issued only by a load that hits, is correct, and leaves its entry in steady. Its address is the load address plus the stride. `pf_valid` rises in the cycle after the load is sampled.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, and no new prefetch is issued, `pf_valid` stays 1 and `pf_addr` does not change.
- R10: A newly issued prefetch replaces any request held in the slot, whatever the state of `pf_ready`.
- R11: A handshake (`pf_valid` and `pf_ready` both 1) with no new prefetch in the same cycle clears `pf_valid` in the next cycle.
- R12: The table index is PC bits [ALIGN_BITS+IDX_W-1:ALIGN_BITS] and the tag is the PC bits above them. Two PCs with the same index evict each other. PCs with different indices learn independently.
- R13: Cycles with `ld_valid` at 0 change neither the table nor the output slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | Program counter of the load |
| ld_addr | input | ADDR_W | Data address of the load |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer accepts the request this cycle |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The hardest states to reach from the ports are the two corners of the confidence machine. One is no-prediction, and it must be left correctly. The other is the fall from steady back to init, where the stride must be kept. The stimulus reaches no-prediction through a chosen sequence of addresses: a first guess, then two wrong guesses with different strides, then a repeat that matches. It reaches the other corner by breaking a steady stream once and then resuming on the old stride. A prefetch one step later shows that the stride survived. Separately, the consumer is stalled while two qualifying loads arrive, which shows that the held request is overwritten rather than queued.

// File: rtl/spf_pkg.sv
package spf_pkg;
  typedef enum logic [1:0] {
    CS_INIT   = 2'd0,
    CS_TRANS  = 2'd1,
    CS_STEADY = 2'd2,
    CS_NOPRED = 2'd3
  } conf_t;
endpackage

// File: rtl/spf_hist_table.sv
module spf_hist_table
  import spf_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 26,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_prev,
  output logic [ADDR_W-1:0] rd_stride,
  output conf_t             rd_state,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_prev,
  input  logic [ADDR_W-1:0] wr_stride,
  input  conf_t             wr_state
);
  // The fields live in plain arrays with no reset, so they map onto
  // distributed RAM. Only the valid bits are cleared on reset.
  logic [TAG_W-1:0]  tag_mem    [ENTRIES];
  logic [ADDR_W-1:0] prev_mem   [ENTRIES];
  logic [ADDR_W-1:0] stride_mem [ENTRIES];
  logic [1:0]        state_mem  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]    <= wr_tag;
      prev_mem[wr_idx]   <= wr_prev;
      stride_mem[wr_idx] <= wr_stride;
      state_mem[wr_idx]  <= wr_state;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_mem[rd_idx];
  assign rd_prev   = prev_mem[rd_idx];
  assign rd_stride = stride_mem[rd_idx];
  assign rd_state  = conf_t'(state_mem[rd_idx]);

  // R12: a written entry is valid and carries the written tag afterwards
  p_write_claims_r12: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (valid_q[$past(wr_idx)] && tag_mem[$past(wr_idx)] == $past(wr_tag)));
  // R1: the valid bits are all clear on the first cycle after reset
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (valid_q == '0));
endmodule

// File: rtl/spf_conf_update.sv
module spf_conf_update
  import spf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              hit,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] prev_addr,
  input  logic [ADDR_W-1:0] stride,
  input  conf_t             state,
  output logic [ADDR_W-1:0] nxt_stride,
  output conf_t             nxt_state,
  output logic              issue,
  output logic [ADDR_W-1:0] target
);
  logic              correct;
  logic [ADDR_W-1:0] delta;

  assign correct = (cur_addr == prev_addr + stride);
  assign delta   = cur_addr - prev_addr;
  assign target  = cur_addr + stride;

  always_comb begin
    nxt_stride = stride;
    nxt_state  = state;
    if (!hit) begin
      nxt_stride = '0;
      nxt_state  = CS_INIT;
    end else begin
      unique case (state)
        CS_INIT: begin
          nxt_state = correct ? CS_STEADY : CS_TRANS;
          if (!correct) nxt_stride = delta;
        end
        CS_TRANS: begin
          nxt_state = correct ? CS_STEADY : CS_NOPRED;
          if (!correct) nxt_stride = delta;
        end
        CS_STEADY: begin
          nxt_state = correct ? CS_STEADY : CS_INIT;
        end
        CS_NOPRED: begin
          nxt_state = correct ? CS_TRANS : CS_NOPRED;
          if (!correct) nxt_stride = delta;
        end
        default: nxt_state = CS_INIT;
      endcase
    end
    issue = hit && correct && (nxt_state == CS_STEADY);
  end
endmodule

// File: rtl/spf_req_slot.sv
module spf_req_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              pf_ready,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (load) begin
      pf_valid <= 1'b1;
      pf_addr  <= load_addr;
    end else if (pf_valid && pf_ready) begin
      pf_valid <= 1'b0;
    end
  end

  // R9: a stalled request is held unchanged
  p_hold_stalled_r9: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready && !load) |=> (pf_valid && $stable(pf_addr)));
  // R10: a new request takes the slot
  p_newest_wins_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> (pf_valid && pf_addr == $past(load_addr)));
  // R11: an accepted request leaves the slot
  p_drain_after_hs_r11: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_ready && !load) |=> !pf_valid);
endmodule

// File: rtl/spf_stride_prefetcher.sv
module spf_stride_prefetcher
  import spf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PC_W       = 32,
  parameter int ENTRIES    = 16,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - ALIGN_BITS - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [ALIGN_BITS-1:0] unused_align;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_prev, rd_stride;
  conf_t             rd_state;
  logic              hit;
  logic [ADDR_W-1:0] nxt_stride, target;
  conf_t             nxt_state;
  logic              issue;

  assign unused_align = ld_pc[ALIGN_BITS-1:0];
  assign idx = ld_pc[ALIGN_BITS +: IDX_W];
  assign tag = ld_pc[PC_W-1 -: TAG_W];
  assign hit = rd_valid && (rd_tag == tag);

  spf_hist_table #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .ENTRIES(ENTRIES)
  ) u_table (
    .clk(clk), .rst(rst),
    .rd_idx(idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_prev(rd_prev), .rd_stride(rd_stride), .rd_state(rd_state),
    .wr_en(ld_valid), .wr_idx(idx), .wr_tag(tag),
    .wr_prev(ld_addr), .wr_stride(nxt_stride), .wr_state(nxt_state)
  );

  spf_conf_update #(.ADDR_W(ADDR_W)) u_conf (
    .hit(hit), .cur_addr(ld_addr), .prev_addr(rd_prev),
    .stride(rd_stride), .state(rd_state),
    .nxt_stride(nxt_stride), .nxt_state(nxt_state),
    .issue(issue), .target(target)
  );

  spf_req_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst(rst),
    .load(ld_valid && issue), .load_addr(target),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  // R1: no request pending right after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pf_valid);
  // R2: a tag miss never starts a request
  p_miss_no_issue_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !hit && !pf_valid) |=> !pf_valid);
  // R3: a correct load in init produces a request one stride ahead
  p_init_to_issue_r3: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && hit && rd_state == CS_INIT && ld_addr == rd_prev + rd_stride)
    |=> (pf_valid && pf_addr == $past(ld_addr) + $past(rd_stride)));
  // R5: a load seen in no-prediction never starts a request
  p_nopred_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && hit && rd_state == CS_NOPRED && !pf_valid) |=> !pf_valid);
  // R13: idle cycles start no request
  p_idle_silent_r13: assert property (@(posedge clk) disable iff (rst)
    (!ld_valid && !pf_valid) |=> !pf_valid);
endmodule

// File: tb/tb_spf_stride_prefetcher.sv
module tb_spf_stride_prefetcher;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic [31:0]   ld_pc = '0;
  logic [AW-1:0] ld_addr = '0;
  logic          pf_valid;
  logic          pf_ready = 1'b1;
  logic [AW-1:0] pf_addr;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spf_stride_prefetcher dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_pc(ld_pc),
    .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Driver: one load per call; an expected prefetch goes into the scoreboard.
  task automatic do_load(input logic [31:0] pc, input logic [AW-1:0] a,
                         input bit exp_pf, input logic [AW-1:0] exp_a);
    ld_valid = 1'b1; ld_pc = pc; ld_addr = a;
    if (exp_pf) exp_q.push_back(exp_a);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic drain_check(input string req);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Monitor: every accepted request is compared with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && pf_valid && pf_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected prefetch", pf_addr, 0);
      end else begin
        automatic logic [AW-1:0] e = exp_q.pop_front();
        check(pf_addr == e, "R8 prefetch address", pf_addr, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pf_valid == 1'b0, "R1 pf_valid after reset", pf_valid, 0);

    // R2/R3: miss allocates with stride 0; a repeat address is correct in init
    do_load(32'h208, 32'h5000, 0, 0);
    drain_check("R2 no prefetch on miss");
    do_load(32'h208, 32'h5000, 1, 32'h5000);
    drain_check("R3 init correct issues");

    // R4: init wrong -> transient, relearn; correct -> steady
    do_load(32'h104, 32'h1000, 0, 0);
    do_load(32'h104, 32'h1040, 0, 0);
    drain_check("R4 transient silent");
    do_load(32'h104, 32'h1080, 1, 32'h10C0);
    do_load(32'h104, 32'h10C0, 1, 32'h1100);
    drain_check("R4 steady issues");

    // R6: steady wrong -> init, stride 0x40 kept; resuming on it issues
    do_load(32'h104, 32'h2000, 0, 0);
    drain_check("R6 steady break silent");
    do_load(32'h104, 32'h2040, 1, 32'h2080);
    drain_check("R6 stride kept");

    // R5/R7: walk into no-prediction and back out
    do_load(32'h30C, 32'h00, 0, 0);
    do_load(32'h30C, 32'h10, 0, 0);
    do_load(32'h30C, 32'h30, 0, 0);
    drain_check("R5 transient wrong silent");
    do_load(32'h30C, 32'h38, 0, 0);
    drain_check("R7 nopred wrong silent");
    do_load(32'h30C, 32'h40, 0, 0);
    drain_check("R5 nopred correct silent");
    do_load(32'h30C, 32'h48, 1, 32'h50);
    drain_check("R5 transient to steady");

    // R12: conflicting PC evicts; interleaved PCs stay independent
    do_load(32'h144, 32'h9000, 0, 0);
    do_load(32'h104, 32'h2080, 0, 0);
    drain_check("R12 evicted entry misses");
    do_load(32'h410, 32'h100, 0, 0);
    do_load(32'h514, 32'h8000, 0, 0);
    do_load(32'h410, 32'h200, 0, 0);
    do_load(32'h514, 32'h7FF0, 0, 0);
    do_load(32'h410, 32'h300, 1, 32'h400);
    do_load(32'h514, 32'h7FE0, 1, 32'h7FD0);
    drain_check("R12 independent entries");

    // R13: idle cycles with junk on the load inputs
    ld_pc = 32'h410; ld_addr = 32'hDEAD0;
    repeat (4) @(negedge clk);
    check(pf_valid == 1'b0, "R13 idle no request", pf_valid, 0);
    do_load(32'h410, 32'h400, 1, 32'h500);
    drain_check("R13 entry untouched by idle");

    // R9/R10/R11: stall, hold, overwrite, then drain
    pf_ready = 1'b0;
    do_load(32'h410, 32'h500, 1, 32'h600);
    for (int i = 0; i < 3; i++) begin
      check(pf_valid && pf_addr == 32'h600, "R9 held request", pf_addr, 32'h600);
      @(negedge clk);
    end
    void'(exp_q.pop_front());
    do_load(32'h410, 32'h600, 1, 32'h700);
    check(pf_valid && pf_addr == 32'h700, "R10 replaced request", pf_addr, 32'h700);
    pf_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(pf_valid == 1'b0, "R11 cleared after handshake", pf_valid, 0);
    check(exp_q.size() == 0, "R10 one request delivered", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule